// File: doc/BRIEF.md
# Self-Timed Word Programming Sequencer

This block runs the internal programming phase of a serial non-volatile memory once a write command has been fully shifted in. A separate command decoder hands it one strobe that carries the target address and the 16-bit word. The sequencer then drops the ready/busy line and counts a fixed number of prescale ticks, which stand in for the self-timed programming interval. When the count expires, it pulses a one-cycle write strobe into the storage array. While the cycle runs, every further request is ignored.

The write-control input can cancel a write. A cancel that arrives before programming begins leaves the addressed word untouched. A cancel that arrives during programming stops the cycle at once, never strobes the array, and raises a corruption flag, because the word's contents can no longer be trusted. Once a write has started, the data-out pin can also report the ready/busy level. It does so when chip select falls while the serial clock is low, and it stops when chip select goes high again. Raising chip select while ready returns the block to its idle wait.

Top module: `wr_cycle_ctrl`

## Requirements
- R1: During and right after synchronous reset, `rdy` is 1 and `arr_we`, `dout_oe` and `corrupt` are 0.
- R2: The block accepts a request when `wr_req` is high with `cs_n` low and `wc` low while `rdy` is 1. If `wr_req` is sampled at clock edge k, `rdy` stays 1 after edge k and is 0 after edge k+1.
- R3: Programming ends on the edge that samples the `PROG_TICKS`-th `tick` counted after busy begins. After that edge, `arr_we` is 1 for exactly one cycle with the latched address and data, and `rdy` is 1 again.
- R4: A `wr_req` sampled with `cs_n` high is ignored: `rdy` stays 1 and the array is not written.
- R5: A `wr_req` that arrives while `rdy` is 0 is dropped. The write in progress commits its own address and data, and only one strobe occurs.
- R6: If `wc` is 1 at the request edge or at the following edge, the write is cancelled before it starts, whatever the level of `cs_n`. `rdy` never goes low, no strobe occurs and the word keeps its old value.
- R7: If `wc` is 1 at any edge while busy, then after that edge `rdy` is 1 and `corrupt` is 1, and `arr_we` never pulses for that write.
- R8: If `wc` is 1 on the same edge that samples the final `tick`, the abort of R7 takes priority over the commit of R3.
- R9: The level of `cs_n` during programming has no effect on when the cycle completes or on what it writes.
- R10: Once a write has entered busy, a `cs_n` fall sampled with `sclk` low sets `dout_oe` to 1 after that edge. While `dout_oe` is 1, `dout_bit` equals `rdy`. Any edge that samples `cs_n` high clears `dout_oe`.
- R11: A `cs_n` fall sampled with `sclk` high does not set `dout_oe`.
- R12: A `cs_n` rise sampled while `rdy` is 1 resets the block to idle. After it, a `cs_n` fall with `sclk` low does not set `dout_oe` until another write has started.
- R13: `corrupt` stays set after an abort and clears on the edge that accepts the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_req | input | 1 | One-cycle strobe from the command decoder: a write command is complete |
| wr_addr | input | ADDR_W | Word address carried with the strobe |
| wr_data | input | DATA_W | Word value carried with the strobe |
| cs_n | input | 1 | Chip select, active low, synchronised |
| sclk | input | 1 | Serial clock level, synchronised |
| wc | input | 1 | Write control; 1 cancels or aborts a write |
| tick | input | 1 | Prescale tick for the programming timer |
| rdy | output | 1 | Ready/busy level: 1 ready, 0 programming |
| arr_we | output | 1 | One-cycle array write strobe |
| arr_addr | output | ADDR_W | Latched address for the array |
| arr_data | output | DATA_W | Latched data for the array |
| dout_oe | output | 1 | Data-out pin carries the status bit |
| dout_bit | output | 1 | Status bit for the data-out pin |
| corrupt | output | 1 | Last write was aborted during programming |

## Verification
The two functions that can meet in one cycle are the timer expiring and a write-control abort. The bench drives `wc` high on the very edge that samples the final `tick`, both in a directed case and whenever a random abort position lands on the last tick. In that cycle the bench expects no strobe, a raised `corrupt` and a stored word that the array model never touched. A second overlap is a late request arriving during programming: the bench checks that the commit still carries the original address and data.

// File: rtl/wcc_pkg.sv
package wcc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_PROG = 2'd2,
    ST_DONE = 2'd3
  } wcc_state_e;
endpackage

// File: rtl/wcc_prog_timer.sv
module wcc_prog_timer #(
  parameter int TICKS = 10000,
  localparam int CNT_W = $clog2(TICKS + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic tick,
  output logic expire
);
  logic [CNT_W-1:0] cnt_q;

  assign expire = run && tick && (cnt_q == CNT_W'(TICKS - 1));

  always_ff @(posedge clk) begin
    if (rst || !run || expire) cnt_q <= '0;
    else if (tick)             cnt_q <= cnt_q + 1'b1;
  end

  // R3: the count never passes the programmed length
  p_cnt_below_limit_r3: assert property (@(posedge clk) disable iff (rst)
    cnt_q < CNT_W'(TICKS));
endmodule

// File: rtl/wcc_dout_status.sv
module wcc_dout_status (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sclk,
  input  logic start,
  input  logic ready_now,
  input  logic ready_next,
  output logic dout_oe,
  output logic dout_bit
);
  logic cs_q, armed_q, win_d;
  logic cs_fall, cs_rise;

  assign cs_fall = cs_q && !cs_n;
  assign cs_rise = !cs_q && cs_n;
  assign win_d   = cs_n ? 1'b0
                        : (dout_oe || (cs_fall && !sclk && (armed_q || start)));

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q     <= 1'b1;
      armed_q  <= 1'b0;
      dout_oe  <= 1'b0;
      dout_bit <= 1'b0;
    end else begin
      cs_q <= cs_n;
      if (start)                     armed_q <= 1'b1;
      else if (cs_rise && ready_now) armed_q <= 1'b0;
      dout_oe  <= win_d;
      dout_bit <= win_d && ready_next;
    end
  end

  // R10: chip select high closes the status window on the next edge
  p_oe_closes_on_cs_high_r10: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> !dout_oe);
  // R11: a fall while the serial clock is high never opens the window
  p_no_open_sclk_high_r11: assert property (@(posedge clk) disable iff (rst)
    (cs_q && !cs_n && sclk && !dout_oe) |=> !dout_oe);
endmodule

// File: rtl/wr_cycle_ctrl.sv
module wr_cycle_ctrl
  import wcc_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int DATA_W     = 16,
  parameter int PROG_TICKS = 10000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              wc,
  input  logic              tick,
  output logic              rdy,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_data,
  output logic              dout_oe,
  output logic              dout_bit,
  output logic              corrupt
);
  wcc_state_e state_q, state_d;
  logic cs_q;
  logic ready_state, take_req, accept, go_prog, abort, expire, commit, rdy_d;

  assign ready_state = (state_q == ST_IDLE) || (state_q == ST_DONE);
  assign take_req    = ready_state && wr_req && !cs_n;
  assign accept      = take_req && !wc;
  assign go_prog     = (state_q == ST_ARM) && !wc;
  assign abort       = (state_q == ST_PROG) && wc;
  assign commit      = (state_q == ST_PROG) && !wc && expire;

  wcc_prog_timer #(.TICKS(PROG_TICKS)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .run    (state_q == ST_PROG),
    .tick   (tick),
    .expire (expire)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE, ST_DONE: begin
        if (take_req)                            state_d = wc ? ST_IDLE : ST_ARM;
        else if (state_q == ST_DONE && cs_n && !cs_q) state_d = ST_IDLE;
      end
      ST_ARM:  state_d = wc ? ST_IDLE : ST_PROG;
      ST_PROG: begin
        if (wc)          state_d = ST_IDLE;
        else if (expire) state_d = ST_DONE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign rdy_d = (state_d != ST_PROG);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      cs_q     <= 1'b1;
      rdy      <= 1'b1;
      arr_we   <= 1'b0;
      arr_addr <= '0;
      arr_data <= '0;
      corrupt  <= 1'b0;
    end else begin
      state_q <= state_d;
      cs_q    <= cs_n;
      rdy     <= rdy_d;
      arr_we  <= commit;
      if (accept) begin
        arr_addr <= wr_addr;
        arr_data <= wr_data;
      end
      if (abort)       corrupt <= 1'b1;
      else if (accept) corrupt <= 1'b0;
    end
  end

  wcc_dout_status u_status (
    .clk        (clk),
    .rst        (rst),
    .cs_n       (cs_n),
    .sclk       (sclk),
    .start      (go_prog),
    .ready_now  (rdy),
    .ready_next (rdy_d),
    .dout_oe    (dout_oe),
    .dout_bit   (dout_bit)
  );

  // R2: an armed write without cancel turns busy on the next edge
  p_busy_entry_r2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ARM && !wc) |=> !rdy);
  // R3: the strobe is one cycle wide and follows a busy cycle
  p_we_single_r3: assert property (@(posedge clk) disable iff (rst)
    arr_we |=> !arr_we);
  p_we_after_busy_r3: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> $past(!rdy));
  // R5: requests seen while busy leave the latched word alone
  p_drop_while_busy_r5: assert property (@(posedge clk) disable iff (rst)
    (!rdy && wr_req) |=> ($stable(arr_addr) && $stable(arr_data)));
  // R6: cancel before programming never shows busy or a strobe
  p_precancel_r6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ARM && wc) |=> (rdy && !arr_we));
  // R7 and R8: abort during programming wins over the expiring timer
  p_abort_r7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_PROG && wc) |=> (rdy && corrupt && !arr_we));
endmodule

// File: tb/wr_cycle_ctrl_test.sv
module wr_cycle_ctrl_test;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int NT = 6;

  logic clk = 1'b0;
  logic rst, wr_req, cs_n, sclk, wc, tick;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic rdy, arr_we, dout_oe, dout_bit, corrupt;
  logic [AW-1:0] arr_addr;
  logic [DW-1:0] arr_data;

  int checks = 0, errors = 0, cycles = 0, we_cnt = 0;
  bit we_now = 0, finished = 0;
  logic [DW-1:0] obs_mem [2**AW];
  logic [DW-1:0] ref_mem [2**AW];
  bit exp_corrupt = 0;

  always #10 clk = ~clk;

  wr_cycle_ctrl #(.ADDR_W(AW), .DATA_W(DW), .PROG_TICKS(NT)) uut (
    .clk(clk), .rst(rst), .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
    .cs_n(cs_n), .sclk(sclk), .wc(wc), .tick(tick), .rdy(rdy), .arr_we(arr_we),
    .arr_addr(arr_addr), .arr_data(arr_data), .dout_oe(dout_oe),
    .dout_bit(dout_bit), .corrupt(corrupt));

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    while (cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d cycles, expected fewer", cycles);
    summary();
  end

  task automatic step;
    @(posedge clk);
    #1;
    we_now = arr_we;
    if (arr_we) begin
      obs_mem[arr_addr] = arr_data;
      we_cnt++;
    end
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit mode_writes(input int mode);
    return mode == 0;
  endfunction

  function automatic bit mode_corrupt(input int mode, input bit prev);
    if (mode == 3) return 1'b1;
    if (mode == 1) return prev;
    return 1'b0;
  endfunction

  // mode 0 normal, 1 cancel at strobe, 2 cancel in arm cycle, 3 abort in programming
  task automatic run_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input int mode, input int abort_j, input bit dup);
    int ticks = 0;
    int j = 0;
    bit done = 0;
    int cnt0 = we_cnt;
    wr_req = 1; wr_addr = a; wr_data = d; cs_n = (mode == 1) ? $urandom % 2 : 0;
    wc = (mode == 1);
    step();
    chk("R2 ready before busy", rdy, 1);
    if (mode != 1) chk("R13 corrupt cleared on accept", corrupt, 0);
    wr_req = 0; wc = (mode == 2);
    if (mode == 2) cs_n = $urandom % 2;
    step();
    if (mode == 1 || mode == 2) begin
      chk("R6 no busy after cancel", rdy, 1);
      chk("R6 no strobe after cancel", we_cnt - cnt0, 0);
    end else begin
      chk("R2 busy after accept", rdy, 0);
      while (!done) begin
        bit t = $urandom % 2;
        tick = t;
        wc = (mode == 3 && j == abort_j);
        cs_n = $urandom % 2;
        sclk = $urandom % 2;
        wr_req = dup && (j == 1);
        wr_addr = a ^ 4'h1; wr_data = ~d;
        step();
        wr_req = 0;
        if (wc) begin
          chk("R7 ready after abort", rdy, 1);
          chk("R7 corrupt after abort", corrupt, 1);
          chk("R7 no strobe on abort", we_cnt - cnt0, 0);
          done = 1;
        end else if (t) begin
          ticks++;
          if (ticks == NT) begin
            chk("R3 strobe at last tick", we_now, 1);
            chk("R3 ready at end", rdy, 1);
            chk("R5 committed address", arr_addr, a);
            chk("R5 committed data", arr_data, d);
            done = 1;
          end else chk("R3 still busy", rdy, 0);
        end else chk("R9 still busy", rdy, 0);
        j++;
      end
      tick = 0; wc = 0;
      step();
      chk("R3 strobe one cycle", we_now, 0);
    end
    if (mode_writes(mode)) ref_mem[a] = d;
    exp_corrupt = mode_corrupt(mode, exp_corrupt);
    chk("R3 R6 R7 stored word", obs_mem[a], ref_mem[a]);
    chk("R5 strobe count", we_cnt - cnt0, mode_writes(mode) ? 1 : 0);
    chk("R13 corrupt flag", corrupt, exp_corrupt);
    wc = 0; cs_n = 1; sclk = 0;
    step();
  endtask

  task automatic start_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    wr_req = 1; wr_addr = a; wr_data = d; cs_n = 0; wc = 0;
    step();
    wr_req = 0;
    step();
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 2**AW; i++) begin obs_mem[i] = '0; ref_mem[i] = '0; end
    rst = 1; wr_req = 0; wr_addr = '0; wr_data = '0; cs_n = 1; sclk = 0; wc = 0; tick = 0;
    step(); step();
    chk("R1 rdy in reset", rdy, 1);
    chk("R1 we in reset", arr_we, 0);
    chk("R1 oe in reset", dout_oe, 0);
    chk("R1 corrupt in reset", corrupt, 0);
    rst = 0;
    step();
    chk("R1 rdy after reset", rdy, 1);

    // R4: request with chip select high is ignored
    wr_req = 1; wr_addr = 4'h2; wr_data = 16'h1111; cs_n = 1;
    step(); wr_req = 0; step();
    chk("R4 no busy with cs high", rdy, 1);
    tick = 1;
    for (int k = 0; k < NT + 2; k++) step();
    tick = 0;
    chk("R4 no strobe", we_cnt, 0);

    // normal write, then a dropped request while busy (R5)
    run_write(4'h3, 16'hBEEF, 0, 0, 0);
    run_write(4'h4, 16'h1234, 0, 0, 1);
    // cancel cases (R6) and abort (R7)
    run_write(4'h3, 16'h0BAD, 1, 0, 0);
    run_write(4'h3, 16'h0BAD, 2, 0, 0);
    run_write(4'h4, 16'hDEAD, 3, 2, 0);
    run_write(4'h5, 16'h5555, 0, 0, 0);

    // R8: abort on the final tick
    start_write(4'h6, 16'h6666);
    tick = 1;
    for (int k = 0; k < NT - 1; k++) step();
    wc = 1;
    step();
    chk("R8 no strobe on final tick abort", we_now, 0);
    chk("R8 corrupt set", corrupt, 1);
    chk("R8 ready", rdy, 1);
    tick = 0; wc = 0;
    step();
    chk("R8 word unchanged", obs_mem[6], ref_mem[6]);
    cs_n = 1; step();

    // R13: next accepted request clears the flag
    wr_req = 1; wr_addr = 4'h7; wr_data = 16'h7777; cs_n = 0;
    step();
    wr_req = 0;
    chk("R13 corrupt cleared", corrupt, 0);
    step();
    tick = 1;
    for (int k = 0; k < NT; k++) step();
    tick = 0;
    ref_mem[7] = 16'h7777;
    chk("R3 directed commit", obs_mem[7], 16'h7777);
    cs_n = 1; step();

    // R10 and R12: status on the data-out pin
    start_write(4'h8, 16'hA5A5);
    cs_n = 1; sclk = 0; step();
    cs_n = 0; step();
    chk("R10 window opens while busy", dout_oe, 1);
    chk("R10 shows busy", dout_bit, 0);
    tick = 1;
    for (int k = 0; k < NT; k++) step();
    tick = 0;
    chk("R10 window still open", dout_oe, 1);
    chk("R10 shows ready", dout_bit, 1);
    ref_mem[8] = 16'hA5A5;
    cs_n = 1; step();
    chk("R10 window closes on cs high", dout_oe, 0);
    cs_n = 0; sclk = 0; step();
    chk("R12 no window after reset by cs", dout_oe, 0);
    cs_n = 1; step();

    // R11: fall with serial clock high
    start_write(4'h9, 16'h9999);
    cs_n = 1; step();
    sclk = 1; cs_n = 0; step();
    chk("R11 no window with sclk high", dout_oe, 0);
    sclk = 0; tick = 1;
    for (int k = 0; k < NT; k++) step();
    tick = 0;
    ref_mem[9] = 16'h9999;
    chk("R9 write completes", obs_mem[9], 16'h9999);
    cs_n = 1; step();

    // random mix
    for (int i = 0; i < 40; i++) begin
      logic [AW-1:0] a = AW'($urandom);
      logic [DW-1:0] d = DW'($urandom);
      int mode = $urandom % 4;
      run_write(a, d, mode, $urandom % NT, ($urandom % 4) == 0);
    end

    summary();
  end
endmodule